// File: doc/BRIEF.md
# Instruction Pointer with Hardware Loop Counters

This block holds the program address of a small processor core together with two hardware loop counters. Its output always presents the address of the next instruction to fetch. Each fetch strobe moves that address forward by one word. Software can load the pointer through a register-write port, which forces a jump. A decrement-and-branch request picks one loop counter and decrements it. The request redirects program flow to a supplied target unless the counter has just reached zero.

All three registers can be read combinationally through a register-select port. Reads have no side effects. When several requests fall in the same cycle, the pointer follows a fixed priority: direct write first, then branch redirect, then sequential advance.

Reset is asserted asynchronously and released synchronously. Release goes through a two-stage synchronizer, so the registers leave reset on the second rising clock edge after `rst_n` goes high.

Top module: `pcflow_unit`

## Requirements
- R1: While `rst_n` is low, the pointer reads 8000h and both loop counters read 0000h.
- R2: A fetch strobe with no pointer write and no taken branch makes `fetch_addr_o` one higher on the next cycle, wrapping FFFFh to 0000h. With no request at all, the pointer holds its value.
- R3: A register write with select code 0 loads the pointer on the next cycle. This write overrides a fetch increment and a branch redirect in the same cycle.
- R4: `rd_data_o` returns combinationally the register chosen by `rd_sel_i`: code 0 for the pointer, 1 for counter 0, 2 for counter 1, and 0000h for code 3. A read changes no register.
- R5: A register write with code 1 or 2 loads counter 0 or counter 1 on the next cycle. A write with code 3 changes no register.
- R6: A decrement-and-branch request with `dnb_sel_i`=0 or 1 lowers that counter by one on the next cycle, wrapping 0000h to FFFFh. The other counter keeps its value.
- R7: When the decremented value is nonzero, the branch is taken and the pointer equals `dnb_target_i` on the next cycle, even if a fetch strobe is present.
- R8: When the decremented value is zero, the branch is not taken. The pointer advances if a fetch strobe is present and otherwise holds.
- R9: When a register write and a decrement-and-branch address the same counter in the same cycle, the counter takes the written value. The branch decision still uses the counter value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_i | input | 1 | Program fetch strobe |
| fetch_addr_o | output | 16 | Address of the next instruction |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 16 | Register write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 16 | Read data, combinational |
| dnb_req_i | input | 1 | Decrement-and-branch request |
| dnb_sel_i | input | 1 | Loop counter picked by the request |
| dnb_target_i | input | 16 | Branch target address |

## Verification
Every register update lands on the first rising edge after the request. The bench therefore drives inputs 2 ns after an edge and reads results 2 ns after the following edge. Read data depends only on the select input and the registers, so it is checked in the same cycle the select is applied, with no other request active. Reset values are checked while `rst_n` is still low. Normal stimulus starts only after the two synchronizer edges that follow release.

// File: rtl/pcflow_pkg.sv
package pcflow_pkg;
  // Register select code for the instruction pointer; counter k uses k+1.
  localparam int unsigned SEL_PTR_CODE = 0;

  // Width of a select code able to name the pointer and every counter.
  function automatic int unsigned sel_width(input int unsigned num_lc);
    int unsigned w;
    w = 1;
    while ((1 << w) < (num_lc + 1)) w = w + 1;
    return w;
  endfunction

  // Width of an index naming one loop counter.
  function automatic int unsigned idx_width(input int unsigned num_lc);
    int unsigned w;
    w = 1;
    while ((1 << w) < num_lc) w = w + 1;
    return w;
  endfunction
endpackage

// File: rtl/pcflow_rst_sync.sv
module pcflow_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pcflow_ptr.sv
module pcflow_ptr #(
  parameter int unsigned        ADDR_W  = 16,
  parameter logic [ADDR_W-1:0]  RST_VAL = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              redir_en,
  input  logic [ADDR_W-1:0] redir_addr,
  input  logic              fetch,
  output logic [ADDR_W-1:0] ptr_q
);
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_ce;

  // Priority: direct write, then redirect, then sequential advance.
  always_comb begin
    ptr_ce = wr_en | redir_en | fetch;
    if (wr_en)         ptr_d = wr_data;
    else if (redir_en) ptr_d = redir_addr;
    else               ptr_d = ptr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= RST_VAL;
    else if (ptr_ce) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/pcflow_loopctr.sv
module pcflow_loopctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             dec_en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dec_nz
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = wr_en | dec_en;
    cnt_d  = wr_en ? wr_data : (cnt_q - CNT_W'(1));
    // Decremented value is nonzero exactly when the present value is not one.
    dec_nz = (cnt_q != CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pcflow_unit.sv
module pcflow_unit #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_LC  = 2,
  parameter int unsigned PTR_RST = 32'h8000
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       fetch_i,
  output logic [ADDR_W-1:0]                          fetch_addr_o,
  input  logic                                       wr_en_i,
  input  logic [pcflow_pkg::sel_width(NUM_LC)-1:0]   wr_sel_i,
  input  logic [ADDR_W-1:0]                          wr_data_i,
  input  logic [pcflow_pkg::sel_width(NUM_LC)-1:0]   rd_sel_i,
  output logic [ADDR_W-1:0]                          rd_data_o,
  input  logic                                       dnb_req_i,
  input  logic [pcflow_pkg::idx_width(NUM_LC)-1:0]   dnb_sel_i,
  input  logic [ADDR_W-1:0]                          dnb_target_i
);
  import pcflow_pkg::*;

  localparam int unsigned SEL_W = sel_width(NUM_LC);
  localparam int unsigned IDX_W = idx_width(NUM_LC);

  logic                            rst_sync_n;
  logic                            ptr_wr;
  logic                            redir_en;
  logic [NUM_LC-1:0]               cnt_wr;
  logic [NUM_LC-1:0]               cnt_dec;
  logic [NUM_LC-1:0]               cnt_nz;
  logic [NUM_LC-1:0][CNT_W-1:0]    cnt_q;
  logic [ADDR_W-1:0]               ptr_q;

  pcflow_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ptr_wr = wr_en_i && (wr_sel_i == SEL_W'(SEL_PTR_CODE));

  genvar k;
  generate
    for (k = 0; k < NUM_LC; k++) begin : g_lc
      assign cnt_wr[k]  = wr_en_i && (wr_sel_i == SEL_W'(k + 1));
      assign cnt_dec[k] = dnb_req_i && (dnb_sel_i == IDX_W'(k));

      pcflow_loopctr #(.CNT_W(CNT_W)) lc_i (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .wr_en   (cnt_wr[k]),
        .wr_data (wr_data_i[CNT_W-1:0]),
        .dec_en  (cnt_dec[k]),
        .cnt_q   (cnt_q[k]),
        .dec_nz  (cnt_nz[k])
      );
    end
  endgenerate

  // A request naming a counter decides the branch from that counter's state.
  always_comb begin
    redir_en = 1'b0;
    for (int unsigned i = 0; i < NUM_LC; i++) begin
      if (cnt_dec[i]) redir_en = cnt_nz[i];
    end
  end

  pcflow_ptr #(
    .ADDR_W  (ADDR_W),
    .RST_VAL (ADDR_W'(PTR_RST))
  ) ptr_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (ptr_wr),
    .wr_data    (wr_data_i),
    .redir_en   (redir_en),
    .redir_addr (dnb_target_i),
    .fetch      (fetch_i),
    .ptr_q      (ptr_q)
  );

  assign fetch_addr_o = ptr_q;

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i == SEL_W'(SEL_PTR_CODE)) rd_data_o = ptr_q;
    for (int unsigned i = 0; i < NUM_LC; i++) begin
      if (rd_sel_i == SEL_W'(i + 1)) rd_data_o = ADDR_W'(cnt_q[i]);
    end
  end
endmodule

// File: rtl/pcflow_unit_chk.sv
module pcflow_unit_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned NUM_LC = 2,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned IDX_W  = 1
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         rst_sync_n,
  input logic                         fetch_i,
  input logic [ADDR_W-1:0]            fetch_addr_o,
  input logic                         wr_en_i,
  input logic [SEL_W-1:0]             wr_sel_i,
  input logic [ADDR_W-1:0]            wr_data_i,
  input logic                         dnb_req_i,
  input logic [IDX_W-1:0]             dnb_sel_i,
  input logic [ADDR_W-1:0]            dnb_target_i,
  input logic [NUM_LC-1:0][CNT_W-1:0] cnt_q
);
  logic wr_ptr;
  assign wr_ptr = wr_en_i && (wr_sel_i == '0);

  assert_reset_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> fetch_addr_o == ADDR_W'(16'h8000));

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_i && !wr_ptr && !dnb_req_i |=> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !fetch_i && !wr_ptr && !dnb_req_i |=> $stable(fetch_addr_o));

  assert_ptr_load_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_ptr |=> fetch_addr_o == $past(wr_data_i));

  genvar k;
  generate
    for (k = 0; k < NUM_LC; k++) begin : g_chk
      assert_cnt_dec_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        dnb_req_i && dnb_sel_i == IDX_W'(k) && !(wr_en_i && wr_sel_i == SEL_W'(k + 1))
        |=> cnt_q[k] == CNT_W'($past(cnt_q[k]) - 1));

      assert_cnt_keep_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !(dnb_req_i && dnb_sel_i == IDX_W'(k)) && !(wr_en_i && wr_sel_i == SEL_W'(k + 1))
        |=> $stable(cnt_q[k]));

      assert_cnt_load_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        wr_en_i && wr_sel_i == SEL_W'(k + 1) |=> cnt_q[k] == CNT_W'($past(wr_data_i)));

      assert_taken_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
        dnb_req_i && dnb_sel_i == IDX_W'(k) && !wr_ptr && cnt_q[k] != CNT_W'(1)
        |=> fetch_addr_o == $past(dnb_target_i));

      assert_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
        dnb_req_i && dnb_sel_i == IDX_W'(k) && !wr_ptr && cnt_q[k] == CNT_W'(1) && fetch_i
        |=> fetch_addr_o == ADDR_W'($past(fetch_addr_o) + 1));
    end
  endgenerate
endmodule

bind pcflow_unit pcflow_unit_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .NUM_LC (NUM_LC),
  .SEL_W  (SEL_W),
  .IDX_W  (IDX_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .fetch_i      (fetch_i),
  .fetch_addr_o (fetch_addr_o),
  .wr_en_i      (wr_en_i),
  .wr_sel_i     (wr_sel_i),
  .wr_data_i    (wr_data_i),
  .dnb_req_i    (dnb_req_i),
  .dnb_sel_i    (dnb_sel_i),
  .dnb_target_i (dnb_target_i),
  .cnt_q        (cnt_q)
);

// File: tb/pcflow_unit_tb_top.sv
module pcflow_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic        fetch_i;
  logic [15:0] fetch_addr_o;
  logic        wr_en_i;
  logic [1:0]  wr_sel_i;
  logic [15:0] wr_data_i;
  logic [1:0]  rd_sel_i;
  logic [15:0] rd_data_o;
  logic        dnb_req_i;
  logic        dnb_sel_i;
  logic [15:0] dnb_target_i;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  pcflow_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_i      (fetch_i),
    .fetch_addr_o (fetch_addr_o),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .rd_sel_i     (rd_sel_i),
    .rd_data_o    (rd_data_o),
    .dnb_req_i    (dnb_req_i),
    .dnb_sel_i    (dnb_sel_i),
    .dnb_target_i (dnb_target_i)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = 0;
    dnb_req_i = 0; dnb_sel_i = 0; dnb_target_i = 0;
  endtask

  // Advance one edge; inputs and samples sit 2 ns after the edge.
  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] val);
    rd_sel_i = sel; #1; val = rd_data_o;
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [15:0] d);
    idle(); wr_en_i = 1; wr_sel_i = sel; wr_data_i = d; step(); idle();
  endtask

  task automatic t_reset();
    logic [15:0] v;
    idle(); rd_sel_i = 0; rst_n = 0;
    repeat (3) step();
    check("R1 ptr in reset", fetch_addr_o, 16'h8000);
    rd(2'd1, v); check("R1 cnt0 in reset", v, 16'h0000);
    rd(2'd2, v); check("R1 cnt1 in reset", v, 16'h0000);
    rst_n = 1;
    repeat (3) step();
    check("R1 ptr after release", fetch_addr_o, 16'h8000);
  endtask

  task automatic t_fetch();
    logic [15:0] v;
    idle(); fetch_i = 1;
    repeat (3) step();
    idle();
    check("R2 three fetches", fetch_addr_o, 16'h8003);
    step();
    check("R2 hold without fetch", fetch_addr_o, 16'h8003);
    rd(2'd0, v); check("R4 read ptr", v, 16'h8003);
    step(); step();
    check("R4 read has no effect", fetch_addr_o, 16'h8003);
    wreg(2'd0, 16'hFFFF);
    fetch_i = 1; step(); idle();
    check("R2 wrap", fetch_addr_o, 16'h0000);
  endtask

  task automatic t_ptr_write();
    wreg(2'd1, 16'h0005);
    idle(); wr_en_i = 1; wr_sel_i = 0; wr_data_i = 16'h1234;
    fetch_i = 1; dnb_req_i = 1; dnb_sel_i = 0; dnb_target_i = 16'h4444;
    step(); idle();
    check("R3 write beats branch and fetch", fetch_addr_o, 16'h1234);
  endtask

  task automatic t_cnt_write();
    logic [15:0] v;
    wreg(2'd1, 16'h0005);
    wreg(2'd2, 16'h000A);
    wreg(2'd3, 16'h7777);
    rd(2'd1, v); check("R5 cnt0 load", v, 16'h0005);
    rd(2'd2, v); check("R5 cnt1 load", v, 16'h000A);
    rd(2'd3, v); check("R4 code 3 reads zero", v, 16'h0000);
    check("R5 code 3 write ignored by ptr", fetch_addr_o, 16'h1234);
  endtask

  task automatic t_loop();
    logic [15:0] v;
    wreg(2'd1, 16'h0003);
    for (int i = 0; i < 2; i++) begin
      idle(); fetch_i = 1; dnb_req_i = 1; dnb_sel_i = 0; dnb_target_i = 16'h4000;
      step(); idle();
      check("R7 taken over fetch", fetch_addr_o, 16'h4000);
    end
    rd(2'd1, v); check("R6 cnt0 decremented twice", v, 16'h0001);
    idle(); fetch_i = 1; dnb_req_i = 1; dnb_sel_i = 0; dnb_target_i = 16'h4000;
    step(); idle();
    check("R8 not taken advances", fetch_addr_o, 16'h4001);
    rd(2'd1, v); check("R6 cnt0 reaches zero", v, 16'h0000);
    rd(2'd2, v); check("R6 cnt1 untouched", v, 16'h000A);
  endtask

  task automatic t_zero_wrap();
    logic [15:0] v;
    wreg(2'd2, 16'h0000);
    idle(); dnb_req_i = 1; dnb_sel_i = 1; dnb_target_i = 16'h2222;
    step(); idle();
    rd(2'd2, v); check("R6 cnt1 wraps", v, 16'hFFFF);
    check("R7 taken from zero", fetch_addr_o, 16'h2222);
    wreg(2'd1, 16'h0001);
    idle(); dnb_req_i = 1; dnb_sel_i = 0; dnb_target_i = 16'h9999;
    step(); idle();
    check("R8 not taken holds", fetch_addr_o, 16'h2222);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    wreg(2'd2, 16'h0001);
    idle(); wr_en_i = 1; wr_sel_i = 2; wr_data_i = 16'h0009;
    dnb_req_i = 1; dnb_sel_i = 1; dnb_target_i = 16'h5555;
    step(); idle();
    rd(2'd2, v); check("R9 write wins counter", v, 16'h0009);
    check("R9 old value decides not taken", fetch_addr_o, 16'h2222);
    wreg(2'd2, 16'h0005);
    idle(); wr_en_i = 1; wr_sel_i = 2; wr_data_i = 16'h0001;
    dnb_req_i = 1; dnb_sel_i = 1; dnb_target_i = 16'h6666;
    step(); idle();
    rd(2'd2, v); check("R9 write wins counter again", v, 16'h0001);
    check("R9 old value decides taken", fetch_addr_o, 16'h6666);
  endtask

  initial begin
    rst_n = 0; rd_sel_i = 0; idle();
    t_reset();
    t_fetch();
    t_ptr_write();
    t_cnt_write();
    t_loop();
    t_zero_wrap();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule